// File: doc/BRIEF.md
# Random-Number Result and Alarm Register Block

This block is the register front end of a random-number source. An external generator hands over 128-bit results through a valid/ready handshake. The block captures each result as four 32-bit words that software reads over a simple 32-bit register bus. It holds a ready flag until software acknowledges the result. Acknowledging the flag by writing a one to it lets the next result in, so software reads of the data pace the generator.

The same status word also keeps seven sticky health alarms that the generator reports as single-cycle pulses. Each alarm has its own interrupt enable in the control word, and software clears an alarm by writing a one to its bit. The block also holds the generator's configuration: a global enable, a test-mode select, minimum and maximum refill cycle counts and an alarm threshold. It drives all of these to the generator as plain outputs. A read-only revision word completes the map.

Top module: `rng_csr`

## Requirements
- R1: After a synchronous active-low reset, every register reads zero except the revision word, `gen_ready` and `irq` are low, and the configuration outputs are zero.
- R2: When the global enable is set and ready is clear, `gen_ready` is high. A cycle with `gen_valid` high then captures `gen_data`, with bits 32k+31:32k appearing at offset 4k (k = 0..3). Ready (status bit 0, offset 0x10) reads 1 from the next cycle on.
- R3: While ready is set, `gen_ready` is low, `gen_valid` is ignored, and the four data words do not change.
- R4: A write to 0x10 with bit 0 set clears ready. A write to 0x10 with bit 0 clear leaves ready set. If a capture and a clear of ready fall in the same cycle, the capture wins.
- R5: A pulse on `alarm_pulse[k]` sets status bit k+1 at 0x10, and the bit stays set until it is cleared.
- R6: A write to 0x10 clears each alarm bit 7:1 whose data bit is 1 and leaves the others alone. A pulse in the same cycle as the clear keeps that bit set.
- R7: `irq` is high exactly when some status bit in 7:1 is set and the control bit at the same position is set. The ready bit never raises `irq`.
- R8: The control word at 0x14 stores bit 10 (global enable, driven on `gen_enable`), bit 8 (test mode, driven on `test_mode`) and bits 7:1 (alarm interrupt enables). All other bits read zero.
- R9: The config word at 0x18 stores the maximum refill count in bits 31:16 and the minimum refill count in bits 7:0. These drive `refill_max` and `refill_min`, and bits 15:8 read zero.
- R10: The threshold word at 0x1C stores bits 7:0, drives `alarm_thresh`, and reads zero above bit 7.
- R11: The word at 0x7C reads major revision in 27:24, minor in 23:20 and patch in 19:16, with all other bits zero. By default it reads 0x01230000, and writes do not change it.
- R12: Offsets outside the map read zero and writes to them change nothing. Writes to the data word offsets 0x00 to 0x0C are ignored.
- R13: With the global enable clear, `gen_ready` is low and no result is captured.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 8 | Byte offset of the register access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| gen_valid | input | 1 | Generator offers a result |
| gen_data | input | 128 | Generator result |
| gen_ready | output | 1 | Block accepts a result this cycle |
| alarm_pulse | input | 7 | Health alarm pulses; bit k maps to status bit k+1 |
| irq | output | 1 | Interrupt request |
| gen_enable | output | 1 | Global generation enable |
| test_mode | output | 1 | Test mode select |
| refill_max | output | 16 | Maximum refill cycle count |
| refill_min | output | 8 | Minimum refill cycle count |
| alarm_thresh | output | 8 | Alarm threshold |

## Verification
A wrong ready flag shows up on `gen_ready` and in bit 0 of the status word in the same cycle. If it lets a result through too early, the data words change while ready is set, and that is visible on the next read of offsets 0x00 to 0x0C. A lost or stuck alarm bit shows up on `irq` as soon as its enable is set, and in the status word straight away. Configuration faults show on the dedicated outputs one cycle after the write that caused them. Because the bench compares every output against its own model on every clock, any divergence is reported in the cycle it first becomes visible at the ports.

// File: rtl/rng_csr_pkg.sv
// Package: register offsets and field positions shared by the
// random-number register block and its sub-blocks.
package rng_csr_pkg;
    localparam int BUS_W        = 32;
    localparam int OFF_STATUS   = 'h10;
    localparam int OFF_CTRL     = 'h14;
    localparam int OFF_CFG      = 'h18;
    localparam int OFF_THRESH   = 'h1C;
    localparam int OFF_REV      = 'h7C;
    localparam int CTRL_EN_BIT  = 10;
    localparam int CTRL_TST_BIT = 8;
    localparam int CFG_MAX_LSB  = 16;
    localparam int REV_MAJ_LSB  = 24;
    localparam int REV_MIN_LSB  = 20;
    localparam int REV_PAT_LSB  = 16;
endpackage

// File: rtl/rng_result_buf.sv
// Module: rng_result_buf
// Holds one generator result as NUM_WORDS words plus a ready flag.
// Assumes: a capture happens only while enabled and ready is clear;
// the ready flag is cleared by an acknowledge pulse from the bus decode.
module rng_result_buf #(
    parameter int WORD_W    = 32,
    parameter int NUM_WORDS = 4,
    localparam int RES_W    = WORD_W * NUM_WORDS
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             gen_en,
    input  logic             gen_valid,
    input  logic [RES_W-1:0] gen_data,
    input  logic             ack_ready,
    output logic             gen_ready,
    output logic             ready,
    output logic [RES_W-1:0] words
);
    logic ready_q;
    logic take;

    // Handshake: accept only when enabled and the previous result is consumed
    always_comb begin
        gen_ready = gen_en && !ready_q;
        take      = gen_ready && gen_valid;
    end

    // Ready flag: set by a capture, cleared by acknowledge; capture has priority
    always_ff @(posedge clk) begin
        if (!rst_n)         ready_q <= 1'b0;
        else if (take)      ready_q <= 1'b1;
        else if (ack_ready) ready_q <= 1'b0;
    end

    genvar w;
    generate
        for (w = 0; w < NUM_WORDS; w++) begin : g_word
            logic [WORD_W-1:0] word_q;
            // Word storage: load its slice of the result on capture
            always_ff @(posedge clk) begin
                if (!rst_n)    word_q <= '0;
                else if (take) word_q <= gen_data[w*WORD_W +: WORD_W];
            end
            assign words[w*WORD_W +: WORD_W] = word_q;
        end
    endgenerate

    assign ready = ready_q;

    AST_READY_FREEZES_WORDS: assert property (@(posedge clk) disable iff (!rst_n)
        ready_q |=> $stable(words)); // R3
    AST_CAPTURE_SETS_READY: assert property (@(posedge clk) disable iff (!rst_n)
        (gen_ready && gen_valid) |=> (ready_q && words == $past(gen_data))); // R2
    AST_ACK_CLEARS_READY: assert property (@(posedge clk) disable iff (!rst_n)
        (ready_q && ack_ready) |=> !ready_q); // R4
    AST_IDLE_WHEN_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
        (!gen_en && !ready_q) |=> !ready_q); // R13
endmodule

// File: rtl/rng_alarm_stat.sv
// Module: rng_alarm_stat
// Sticky alarm status bits with write-one-to-clear and a masked interrupt.
// Assumes: pulses are single-cycle events; a set in the same cycle as a
// clear keeps the bit set so no event is lost.
module rng_alarm_stat #(
    parameter int NUM_ALARMS = 7
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [NUM_ALARMS-1:0] pulse,
    input  logic [NUM_ALARMS-1:0] clr,
    input  logic [NUM_ALARMS-1:0] en,
    output logic [NUM_ALARMS-1:0] status,
    output logic                  irq
);
    logic [NUM_ALARMS-1:0] stat_q;

    // Status update: clear acknowledged bits, then merge new events
    always_ff @(posedge clk) begin
        if (!rst_n) stat_q <= '0;
        else        stat_q <= (stat_q & ~clr) | pulse;
    end

    // Interrupt: any pending alarm whose enable is set
    always_comb irq = |(stat_q & en);

    assign status = stat_q;

    AST_PULSE_SETS_BIT: assert property (@(posedge clk) disable iff (!rst_n)
        (pulse != '0) |=> ((stat_q & $past(pulse)) == $past(pulse))); // R5
    AST_BIT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (clr == '0) |=> ((stat_q & $past(stat_q)) == $past(stat_q))); // R6
    AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_q == '0) |-> !irq); // R7
endmodule

// File: rtl/rng_cfg_bank.sv
// Module: rng_cfg_bank
// Control, refill configuration and threshold storage for the generator.
// Assumes: write strobes come from the bus decode, one at a time.
module rng_cfg_bank
    import rng_csr_pkg::*;
#(
    parameter int NUM_ALARMS = 7,
    parameter int MAX_W      = 16,
    parameter int MIN_W      = 8,
    parameter int THR_W      = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_ctrl,
    input  logic                  wr_cfg,
    input  logic                  wr_thr,
    input  logic [BUS_W-1:0]      wdata,
    output logic                  gen_en,
    output logic                  test_mode,
    output logic [NUM_ALARMS-1:0] alarm_en,
    output logic [MAX_W-1:0]      refill_max,
    output logic [MIN_W-1:0]      refill_min,
    output logic [THR_W-1:0]      thresh
);
    // Control word: enable, test select and per-alarm interrupt enables
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gen_en    <= 1'b0;
            test_mode <= 1'b0;
            alarm_en  <= '0;
        end else if (wr_ctrl) begin
            gen_en    <= wdata[CTRL_EN_BIT];
            test_mode <= wdata[CTRL_TST_BIT];
            alarm_en  <= wdata[NUM_ALARMS:1];
        end
    end

    // Refill cycle bounds
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            refill_max <= '0;
            refill_min <= '0;
        end else if (wr_cfg) begin
            refill_max <= wdata[CFG_MAX_LSB +: MAX_W];
            refill_min <= wdata[MIN_W-1:0];
        end
    end

    // Alarm threshold
    always_ff @(posedge clk) begin
        if (!rst_n)      thresh <= '0;
        else if (wr_thr) thresh <= wdata[THR_W-1:0];
    end

    AST_CFG_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_cfg |=> ($stable(refill_max) && $stable(refill_min))); // R9
    AST_CTRL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_ctrl |=> ($stable(gen_en) && $stable(alarm_en))); // R8
endmodule

// File: rtl/rng_csr.sv
// Module: rng_csr (top)
// Register front end of a random-number source: decodes the 32-bit
// register bus, builds the read mux and ties together result buffer,
// alarm status and configuration bank.
// Assumes: reads are combinational on bus_addr; writes take effect at
// the clock edge where bus_wr is high.
module rng_csr
    import rng_csr_pkg::*;
#(
    parameter int ADDR_W     = 8,
    parameter int NUM_WORDS  = 4,
    parameter int NUM_ALARMS = 7,
    parameter int MAX_W      = 16,
    parameter int MIN_W      = 8,
    parameter int THR_W      = 8,
    parameter logic [3:0] REV_MAJOR = 4'd1,
    parameter logic [3:0] REV_MINOR = 4'd2,
    parameter logic [3:0] REV_PATCH = 4'd3,
    localparam int RES_W     = BUS_W * NUM_WORDS
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  bus_wr,
    input  logic [ADDR_W-1:0]     bus_addr,
    input  logic [BUS_W-1:0]      bus_wdata,
    output logic [BUS_W-1:0]      bus_rdata,
    input  logic                  gen_valid,
    input  logic [RES_W-1:0]      gen_data,
    output logic                  gen_ready,
    input  logic [NUM_ALARMS-1:0] alarm_pulse,
    output logic                  irq,
    output logic                  gen_enable,
    output logic                  test_mode,
    output logic [MAX_W-1:0]      refill_max,
    output logic [MIN_W-1:0]      refill_min,
    output logic [THR_W-1:0]      alarm_thresh
);
    localparam logic [BUS_W-1:0] REV_WORD =
        (BUS_W'(REV_MAJOR) << REV_MAJ_LSB) |
        (BUS_W'(REV_MINOR) << REV_MIN_LSB) |
        (BUS_W'(REV_PATCH) << REV_PAT_LSB);

    logic                  sel_status, sel_ctrl, sel_cfg, sel_thr, sel_rev;
    logic                  wr_status, wr_ctrl, wr_cfg, wr_thr;
    logic                  ready;
    logic [RES_W-1:0]      words;
    logic [NUM_ALARMS-1:0] alarm_stat, alarm_en, alarm_clr;
    logic                  hit;

    // Address decode for the fixed registers
    always_comb begin
        sel_status = (bus_addr == ADDR_W'(OFF_STATUS));
        sel_ctrl   = (bus_addr == ADDR_W'(OFF_CTRL));
        sel_cfg    = (bus_addr == ADDR_W'(OFF_CFG));
        sel_thr    = (bus_addr == ADDR_W'(OFF_THRESH));
        sel_rev    = (bus_addr == ADDR_W'(OFF_REV));
        wr_status  = bus_wr && sel_status;
        wr_ctrl    = bus_wr && sel_ctrl;
        wr_cfg     = bus_wr && sel_cfg;
        wr_thr     = bus_wr && sel_thr;
        alarm_clr  = wr_status ? bus_wdata[NUM_ALARMS:1] : '0;
    end

    rng_result_buf #(
        .WORD_W    (BUS_W),
        .NUM_WORDS (NUM_WORDS)
    ) u_buf (
        .clk       (clk),
        .rst_n     (rst_n),
        .gen_en    (gen_enable),
        .gen_valid (gen_valid),
        .gen_data  (gen_data),
        .ack_ready (wr_status && bus_wdata[0]),
        .gen_ready (gen_ready),
        .ready     (ready),
        .words     (words)
    );

    rng_alarm_stat #(
        .NUM_ALARMS (NUM_ALARMS)
    ) u_alarm (
        .clk    (clk),
        .rst_n  (rst_n),
        .pulse  (alarm_pulse),
        .clr    (alarm_clr),
        .en     (alarm_en),
        .status (alarm_stat),
        .irq    (irq)
    );

    rng_cfg_bank #(
        .NUM_ALARMS (NUM_ALARMS),
        .MAX_W      (MAX_W),
        .MIN_W      (MIN_W),
        .THR_W      (THR_W)
    ) u_cfg (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_ctrl    (wr_ctrl),
        .wr_cfg     (wr_cfg),
        .wr_thr     (wr_thr),
        .wdata      (bus_wdata),
        .gen_en     (gen_enable),
        .test_mode  (test_mode),
        .alarm_en   (alarm_en),
        .refill_max (refill_max),
        .refill_min (refill_min),
        .thresh     (alarm_thresh)
    );

    // Read mux: data words, then fixed registers; anything else reads zero
    always_comb begin
        bus_rdata = '0;
        hit       = 1'b0;
        for (int i = 0; i < NUM_WORDS; i++) begin
            if (bus_addr == ADDR_W'(4 * i)) begin
                bus_rdata = words[i*BUS_W +: BUS_W];
                hit       = 1'b1;
            end
        end
        if (sel_status) begin
            bus_rdata = BUS_W'({alarm_stat, ready});
            hit       = 1'b1;
        end
        if (sel_ctrl) begin
            bus_rdata = (BUS_W'(gen_enable) << CTRL_EN_BIT) |
                        (BUS_W'(test_mode)  << CTRL_TST_BIT) |
                        (BUS_W'(alarm_en)   << 1);
            hit       = 1'b1;
        end
        if (sel_cfg) begin
            bus_rdata = (BUS_W'(refill_max) << CFG_MAX_LSB) | BUS_W'(refill_min);
            hit       = 1'b1;
        end
        if (sel_thr) begin
            bus_rdata = BUS_W'(alarm_thresh);
            hit       = 1'b1;
        end
        if (sel_rev) begin
            bus_rdata = REV_WORD;
            hit       = 1'b1;
        end
    end

    AST_UNMAPPED_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !hit |-> (bus_rdata == '0)); // R12
    AST_READY_NO_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
        (alarm_stat == '0) |-> !irq); // R7
    AST_REV_CONSTANT: assert property (@(posedge clk) disable iff (!rst_n)
        sel_rev |-> (bus_rdata == REV_WORD)); // R11
endmodule

// File: tb/sim_rng_csr.sv
`timescale 1ns/1ps
// Bench for rng_csr: behavioural reference model updated on every rising
// edge and compared against all outputs on every falling edge, plus
// directed checks for each requirement.
module sim_rng_csr;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         bus_wr = 1'b0;
    logic [7:0]   bus_addr = 8'h00;
    logic [31:0]  bus_wdata = '0;
    logic [31:0]  bus_rdata;
    logic         gen_valid = 1'b0;
    logic [127:0] gen_data = '0;
    logic         gen_ready;
    logic [6:0]   alarm_pulse = '0;
    logic         irq, gen_enable, test_mode;
    logic [15:0]  refill_max;
    logic [7:0]   refill_min, alarm_thresh;

    int n_cmp = 0;
    int n_bad = 0;
    int cyc   = 0;
    bit cmp_on = 1'b0;

    // reference model state
    logic [31:0] m_word [4];
    bit          m_ready;
    logic [6:0]  m_alarm, m_aen;
    bit          m_en, m_test;
    logic [15:0] m_max;
    logic [7:0]  m_min, m_thr;

    always #5 clk = ~clk;

    rng_csr u0 (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .gen_valid(gen_valid),
        .gen_data(gen_data), .gen_ready(gen_ready), .alarm_pulse(alarm_pulse),
        .irq(irq), .gen_enable(gen_enable), .test_mode(test_mode),
        .refill_max(refill_max), .refill_min(refill_min), .alarm_thresh(alarm_thresh)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %08h expected %08h at cycle %0d", req, act, exp, cyc);
        end
    endtask

    function automatic logic [31:0] m_read(input logic [7:0] a);
        case (a)
            8'h00: return m_word[0];
            8'h04: return m_word[1];
            8'h08: return m_word[2];
            8'h0C: return m_word[3];
            8'h10: return {24'h0, m_alarm, m_ready};
            8'h14: return {21'h0, m_en, 1'b0, m_test, m_aen, 1'b0};
            8'h18: return {m_max, 8'h00, m_min};
            8'h1C: return {24'h0, m_thr};
            8'h7C: return 32'h0123_0000;
            default: return 32'h0;
        endcase
    endfunction

    function automatic string req_of(input logic [7:0] a);
        if (a < 8'h10 && a[1:0] == 2'b00) return "R2";
        case (a)
            8'h10: return "R5";
            8'h14: return "R8";
            8'h18: return "R9";
            8'h1C: return "R10";
            8'h7C: return "R11";
            default: return "R12";
        endcase
    endfunction

    // Reference model: next state from the inputs sampled at the rising edge
    always @(posedge clk) begin
        cyc++;
        if (!rst_n) begin
            for (int i = 0; i < 4; i++) m_word[i] = '0;
            m_ready = 0; m_alarm = '0; m_aen = '0; m_en = 0; m_test = 0;
            m_max = '0; m_min = '0; m_thr = '0;
        end else begin
            bit take;
            take = m_en && !m_ready && gen_valid;
            if (take) begin
                for (int i = 0; i < 4; i++) m_word[i] = gen_data[32*i +: 32];
                m_ready = 1;
            end else if (bus_wr && bus_addr == 8'h10 && bus_wdata[0]) begin
                m_ready = 0;
            end
            if (bus_wr && bus_addr == 8'h10) m_alarm = m_alarm & ~bus_wdata[7:1];
            m_alarm = m_alarm | alarm_pulse;
            if (bus_wr && bus_addr == 8'h14) begin
                m_en = bus_wdata[10]; m_test = bus_wdata[8]; m_aen = bus_wdata[7:1];
            end
            if (bus_wr && bus_addr == 8'h18) begin
                m_max = bus_wdata[31:16]; m_min = bus_wdata[7:0];
            end
            if (bus_wr && bus_addr == 8'h1C) m_thr = bus_wdata[7:0];
        end
    end

    // Per-cycle comparison of every output against the model
    always @(negedge clk) begin
        if (cmp_on) begin
            chk("R2",  32'(gen_ready), 32'(m_en && !m_ready));
            chk("R7",  32'(irq), 32'(|(m_alarm & m_aen)));
            chk("R8",  32'(gen_enable), 32'(m_en));
            chk("R8",  32'(test_mode), 32'(m_test));
            chk("R9",  32'(refill_max), 32'(m_max));
            chk("R9",  32'(refill_min), 32'(m_min));
            chk("R10", 32'(alarm_thresh), 32'(m_thr));
            chk(req_of(bus_addr), bus_rdata, m_read(bus_addr));
        end
    end

    // Watchdog: a hung run is a failed check
    always @(posedge clk) begin
        if (cyc > 50000) begin
            n_bad++;
            $display("FAIL watchdog: actual running expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    task automatic idle();
        @(posedge clk); #1;
        bus_wr = 0; gen_valid = 0; alarm_pulse = '0;
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(posedge clk); #1;
        bus_wr = 1; bus_addr = a; bus_wdata = d;
        @(posedge clk); #1;
        bus_wr = 0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        bus_addr = a;
        @(negedge clk);
        d = bus_rdata;
    endtask

    logic [31:0] r;
    logic [127:0] d1, d2;
    logic [7:0] addr_set [12] = '{8'h00, 8'h04, 8'h08, 8'h0C, 8'h10, 8'h14,
                                 8'h18, 8'h1C, 8'h7C, 8'h20, 8'h40, 8'hFC};

    initial begin
        d1 = 128'h4444_4444_3333_3333_2222_2222_1111_1111;
        d2 = 128'hDEAD_BEEF_0BAD_F00D_CAFE_BABE_1234_5678;
        repeat (3) @(posedge clk);
        #1 cmp_on = 1'b1;
        @(posedge clk); #1 rst_n = 1'b1;

        // R1: reset values
        for (int i = 0; i < 8; i++) begin
            rd(addr_set[i], r);
            chk("R1", r, 32'h0);
        end
        chk("R1", 32'({gen_ready, irq, gen_enable}), 32'h0);
        rd(8'h7C, r); chk("R11", r, 32'h0123_0000);
        wr(8'h7C, 32'hFFFF_FFFF);
        rd(8'h7C, r); chk("R11", r, 32'h0123_0000);

        // R13: offered result ignored while disabled
        @(posedge clk); #1 gen_valid = 1; gen_data = d1;
        repeat (2) @(posedge clk);
        #1 gen_valid = 0;
        rd(8'h10, r); chk("R13", r, 32'h0);
        rd(8'h00, r); chk("R13", r, 32'h0);

        // R8: control write, unused bits dropped
        wr(8'h14, 32'hFFFF_FFFF);
        rd(8'h14, r); chk("R8", r, 32'h0000_05FE);
        wr(8'h14, 32'h0000_0400);

        // R2: capture
        @(posedge clk); #1 gen_valid = 1; gen_data = d1;
        @(posedge clk); #1 gen_valid = 1; gen_data = d2;
        rd(8'h10, r); chk("R2", r, 32'h1);
        rd(8'h00, r); chk("R2", r, 32'h1111_1111);
        rd(8'h0C, r); chk("R2", r, 32'h4444_4444);

        // R3: still offering d2 while ready is set
        repeat (3) @(posedge clk);
        rd(8'h04, r); chk("R3", r, 32'h2222_2222);
        chk("R3", 32'(gen_ready), 32'h0);

        // R4: writing zero keeps ready; writing one clears it and d2 enters
        wr(8'h10, 32'h0);
        rd(8'h10, r); chk("R4", r, 32'h1);
        wr(8'h10, 32'h1);
        @(negedge clk);
        rd(8'h00, r); chk("R4", r, 32'h1234_5678);
        idle();
        wr(8'h10, 32'h1);

        // R12: data words and unmapped offsets ignore writes
        wr(8'h00, 32'hFFFF_FFFF);
        rd(8'h00, r); chk("R12", r, 32'h1234_5678);
        wr(8'h40, 32'hFFFF_FFFF);
        rd(8'h40, r); chk("R12", r, 32'h0);

        // R5/R7: alarm sets with interrupts masked
        @(posedge clk); #1 alarm_pulse = 7'b000_0001;
        idle();
        rd(8'h10, r); chk("R5", r, 32'h2);
        chk("R7", 32'(irq), 32'h0);
        wr(8'h14, 32'h0000_0402);
        chk("R7", 32'(irq), 32'h1);

        // R6: clear, then clear with simultaneous pulse
        wr(8'h10, 32'h0000_0002);
        rd(8'h10, r); chk("R6", r, 32'h0);
        chk("R6", 32'(irq), 32'h0);
        @(posedge clk); #1 alarm_pulse = 7'b100_0001;
        idle();
        @(posedge clk); #1 bus_wr = 1; bus_addr = 8'h10; bus_wdata = 32'h0000_0002;
        alarm_pulse = 7'b000_0001;
        idle();
        rd(8'h10, r); chk("R6", r, 32'h82);

        // R7: ready alone never interrupts
        wr(8'h10, 32'hFF);
        wr(8'h14, 32'h0000_04FE);
        @(posedge clk); #1 gen_valid = 1;
        idle();
        rd(8'h10, r); chk("R7", r, 32'h1);
        chk("R7", 32'(irq), 32'h0);

        // R9/R10: configuration fields
        wr(8'h18, 32'hABCD_12EF);
        rd(8'h18, r); chk("R9", r, 32'hABCD_00EF);
        chk("R9", 32'(refill_max), 32'h0000_ABCD);
        wr(8'h1C, 32'h0000_1234);
        rd(8'h1C, r); chk("R10", r, 32'h34);

        // Mixed traffic compared against the model every cycle
        for (int k = 0; k < 4000; k++) begin
            @(posedge clk); #1;
            bus_wr      = ($urandom_range(3) == 0);
            bus_addr    = addr_set[$urandom_range(11)];
            bus_wdata   = $urandom;
            gen_valid   = $urandom_range(1);
            gen_data    = {$urandom, $urandom, $urandom, $urandom};
            alarm_pulse = 7'($urandom & $urandom & $urandom);
        end
        idle();
        @(negedge clk);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule